// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block drives a single-data-rate SDRAM device group from a plain request port. A request names a byte address, says whether it reads or writes, and for a write carries one data word. The block turns each accepted request into a fixed command sequence on the memory pins. The sequence opens the row, performs one read or write beat, and closes the row again. Between requests it issues the periodic auto-refresh that the memory needs.

After reset the block waits out the power-up interval. It then brings the device up with a precharge of all banks, two auto-refreshes and a mode-register load. Only after that does it accept requests. Every timing limit is given as a parameter in nanoseconds. Each one is rounded up to whole clock cycles at elaboration from the clock frequency parameter. Read data is captured a fixed number of cycles after the READ command. That number is the CAS latency plus a board round-trip count, and both are parameters.

Top module: `sdram_seq`

## Requirements
- R1: While reset is high and for the first `ceil(T_PWRUP_NS*CLK_MHZ/1000)` cycles after it falls (25000 at the defaults), the pins carry NOP (`{cs_n,ras_n,cas_n,we_n}` = 0111). During that time `mem_dq_oe`, `rd_valid` and `req_ready` stay low.
- R2: Bring-up issues four commands in this order: PRECHARGE with address bit 10 high, AUTO REFRESH, AUTO REFRESH, then LOAD MODE. LOAD MODE has bank 0 and an address word of zero except bits 6:4, which hold the CAS latency. Bits 2:0 = 000 give a single beat and bit 3 = 0 gives sequential order. The next command follows LOAD MODE by at least `T_MRD_CK` cycles.
- R3: Commands are encoded on `{cs_n,ras_n,cas_n,we_n}` as follows: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001, LOAD MODE 0000.
- R4: `req_addr` is split from the top down into bank (2 bits), row (`ROW_W`), column (`COL_W`) and byte offset (`log2(data bytes)`, ignored). ACTIVE carries bank and row. READ and WRITE carry the bank and the column on the low address bits, with address bit 10 low.
- R5: READ or WRITE follows its ACTIVE by at least the tRCD cycle count (3 at defaults).
- R6: PRECHARGE follows its ACTIVE by at least the minimum tRAS count (6). It follows a WRITE by at least `T_WR_CK` cycles. Two ACTIVEs are at least the tRC count (9) apart.
- R7: ACTIVE and AUTO REFRESH follow the latest PRECHARGE by at least the tRP count (3).
- R8: No command follows an AUTO REFRESH by fewer than the tRFC count (9) cycles.
- R9: No row stays open for as long as the maximum tRAS count (15000).
- R10: After bring-up, auto-refresh recurs every `T_REF_NS / 2^ROW_W` ns (976 cycles at defaults). It is late by at most one access. A pending refresh is issued before a waiting request.
- R11: `mem_dq_oe` is high only in the WRITE command cycle, and then `mem_dq_o` equals the request's write data.
- R12: `dq_in` is sampled at the rising edge that lies `CAS_LAT + RTT` cycles after the edge that put READ on the pins (5 at defaults). The sample appears on `rd_data` with `rd_valid` high for exactly one cycle.
- R13: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. ACTIVE is on the pins in the cycle after that edge. READ or WRITE follows, then a single-bank PRECHARGE (bit 10 low) to the same bank, before another request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and memory clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 27 | Byte address |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request is taken on this edge if valid |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 32 | Captured read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | 2 | Bank select |
| mem_addr | output | 13 | Row, column or mode word |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_o | output | 32 | Data driven to memory |
| mem_dq_i | input | 32 | Data returned from memory |

## Verification
The hardest situation to reach is a refresh that falls due while a request is already waiting. The idle path never shows the priority rule, and a single access rarely overlaps the refresh tick. The bench streams two hundred back-to-back writes and raises `req_valid` again as soon as each access closes. This guarantees that several refresh ticks land while a request is pending. A pin-level memory model checks that each such refresh still precedes the ACTIVE and keeps the spacing rules.

// File: rtl/sdram_seq.sv
module sdram_seq #(
  parameter int CLK_MHZ      = 125,
  parameter int DEV_W        = 8,
  parameter int GROUPS       = 4,
  parameter int BANK_W       = 2,
  parameter int ROW_W        = 13,
  parameter int COL_W        = 10,
  parameter int CAS_LAT      = 3,
  parameter int RTT          = 2,
  parameter int T_PWRUP_NS   = 200000,
  parameter int T_RAS_MIN_NS = 44,
  parameter int T_RAS_MAX_NS = 120000,
  parameter int T_RC_NS      = 66,
  parameter int T_RCD_NS     = 20,
  parameter int T_REF_NS     = 64000000,
  parameter int T_RFC_NS     = 66,
  parameter int T_RP_NS      = 20,
  parameter int T_MRD_CK     = 2,
  parameter int T_WR_CK      = 2,
  localparam int DQ_W        = DEV_W * GROUPS,
  localparam int BYTE_W      = $clog2(DQ_W / 8),
  localparam int ADDR_W      = BANK_W + ROW_W + COL_W + BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DQ_W-1:0]   req_wdata,
  output logic              req_ready,
  output logic              rd_valid,
  output logic [DQ_W-1:0]   rd_data,
  output logic              mem_cs_n,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic [BANK_W-1:0] mem_ba,
  output logic [ROW_W-1:0]  mem_addr,
  output logic              mem_dq_oe,
  output logic [DQ_W-1:0]   mem_dq_o,
  input  logic [DQ_W-1:0]   mem_dq_i
);

  function automatic int ns2ck(input int ns);
    return (ns * CLK_MHZ + 999) / 1000;
  endfunction

  function automatic int mx(input int x, input int y);
    return (x > y) ? x : y;
  endfunction

  localparam int C_PWRUP  = mx(ns2ck(T_PWRUP_NS), 1);
  localparam int C_RCD    = ns2ck(T_RCD_NS);
  localparam int C_RP     = ns2ck(T_RP_NS);
  localparam int C_RAS    = ns2ck(T_RAS_MIN_NS);
  localparam int C_RC     = ns2ck(T_RC_NS);
  localparam int C_RFC    = ns2ck(T_RFC_NS);
  localparam int C_RASMAX = (T_RAS_MAX_NS * CLK_MHZ) / 1000;
  localparam int C_REFI   = mx(((T_REF_NS >> ROW_W) * CLK_MHZ) / 1000, 2);

  localparam int G_ACT = mx(C_RCD, 1);
  localparam int G_RD  = mx(C_RAS - G_ACT, 1);
  localparam int G_WR  = mx(C_RAS - G_ACT, mx(T_WR_CK, 1));
  localparam int G_PR  = mx(C_RP, C_RC - G_ACT - G_RD);
  localparam int G_PW  = mx(C_RP, C_RC - G_ACT - G_WR);
  localparam int G_RFC = mx(C_RFC, 1);
  localparam int G_MRD = mx(T_MRD_CK, 1);
  localparam int G_RP  = mx(C_RP, 1);
  localparam int SLACK = G_ACT + mx(G_RD, G_WR) + mx(G_PR, G_PW) + G_RFC + 2;

  localparam int CNT_W  = $clog2(C_PWRUP + 1);
  localparam int REFI_W = $clog2(C_REFI + 1);
  localparam int SW     = $clog2(mx(C_RASMAX, C_REFI + SLACK) + 2);
  localparam int PIPE_L = CAS_LAT + RTT;

  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_ACT = 4'b0011;
  localparam logic [3:0] CMD_RD  = 4'b0101;
  localparam logic [3:0] CMD_WR  = 4'b0100;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_MRS = 4'b0000;

  localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT << 4);

  typedef enum logic [2:0] {
    ST_PWR, ST_IREF1, ST_IREF2, ST_IMRS, ST_IDLE, ST_RW, ST_PRE
  } st_t;

  st_t               st, st_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [REFI_W-1:0] refi;
  logic              ref_pend, ref_clr, refi_wrap;
  logic [3:0]        cmd_q, cmd_n;
  logic [BANK_W-1:0] ba_q, ba_n;
  logic [ROW_W-1:0]  a_q, a_n;
  logic              oe_q, oe_n;
  logic [DQ_W-1:0]   dqo_q;
  logic [BANK_W-1:0] bank_l;
  logic [ROW_W-1:0]  row_l;
  logic [COL_W-1:0]  col_l;
  logic              wr_l;
  logic [DQ_W-1:0]   wd_l;
  logic [PIPE_L-1:0] rpipe;
  logic              take, rd_go;

  generate
    if (BYTE_W > 0) begin : g_lsb
      logic unused_lsb;
      assign unused_lsb = ^req_addr[BYTE_W-1:0];
    end
  endgenerate

  assign req_ready = (st == ST_IDLE) && (cnt == '0) && !ref_pend;
  assign take      = req_valid && req_ready;
  assign rd_go     = (st == ST_RW) && (cnt == '0) && !wr_l;
  assign refi_wrap = (refi == REFI_W'(C_REFI - 1));

  assign {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = cmd_q;
  assign mem_ba    = ba_q;
  assign mem_addr  = a_q;
  assign mem_dq_oe = oe_q;
  assign mem_dq_o  = dqo_q;

  always_comb begin
    st_n    = st;
    cnt_n   = (cnt != '0) ? cnt - 1'b1 : '0;
    cmd_n   = CMD_NOP;
    ba_n    = '0;
    a_n     = '0;
    oe_n    = 1'b0;
    ref_clr = 1'b0;
    if (cnt == '0) begin
      case (st)
        ST_PWR: begin
          cmd_n     = CMD_PRE;
          a_n[10]   = 1'b1;
          cnt_n     = CNT_W'(G_RP - 1);
          st_n      = ST_IREF1;
        end
        ST_IREF1: begin
          cmd_n = CMD_REF;
          cnt_n = CNT_W'(G_RFC - 1);
          st_n  = ST_IREF2;
        end
        ST_IREF2: begin
          cmd_n = CMD_REF;
          cnt_n = CNT_W'(G_RFC - 1);
          st_n  = ST_IMRS;
        end
        ST_IMRS: begin
          cmd_n = CMD_MRS;
          a_n   = MODE_WORD;
          cnt_n = CNT_W'(G_MRD - 1);
          st_n  = ST_IDLE;
        end
        ST_IDLE: begin
          if (ref_pend) begin
            cmd_n   = CMD_REF;
            cnt_n   = CNT_W'(G_RFC - 1);
            ref_clr = 1'b1;
          end else if (req_valid) begin
            cmd_n = CMD_ACT;
            ba_n  = req_addr[BYTE_W+COL_W+ROW_W +: BANK_W];
            a_n   = req_addr[BYTE_W+COL_W +: ROW_W];
            cnt_n = CNT_W'(G_ACT - 1);
            st_n  = ST_RW;
          end
        end
        ST_RW: begin
          cmd_n = wr_l ? CMD_WR : CMD_RD;
          ba_n  = bank_l;
          a_n   = ROW_W'(col_l);
          oe_n  = wr_l;
          cnt_n = wr_l ? CNT_W'(G_WR - 1) : CNT_W'(G_RD - 1);
          st_n  = ST_PRE;
        end
        ST_PRE: begin
          cmd_n = CMD_PRE;
          ba_n  = bank_l;
          cnt_n = wr_l ? CNT_W'(G_PW - 1) : CNT_W'(G_PR - 1);
          st_n  = ST_IDLE;
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_PWR;
      cnt      <= CNT_W'(C_PWRUP - 1);
      cmd_q    <= CMD_NOP;
      ba_q     <= '0;
      a_q      <= '0;
      oe_q     <= 1'b0;
      refi     <= '0;
      ref_pend <= 1'b0;
      rpipe    <= '0;
      rd_valid <= 1'b0;
    end else begin
      st       <= st_n;
      cnt      <= cnt_n;
      cmd_q    <= cmd_n;
      ba_q     <= ba_n;
      a_q      <= a_n;
      oe_q     <= oe_n;
      refi     <= refi_wrap ? '0 : refi + 1'b1;
      ref_pend <= (ref_pend && !ref_clr) || refi_wrap;
      rpipe    <= {rpipe[PIPE_L-2:0], rd_go};
      rd_valid <= rpipe[PIPE_L-1];
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      bank_l <= req_addr[BYTE_W+COL_W+ROW_W +: BANK_W];
      row_l  <= req_addr[BYTE_W+COL_W +: ROW_W];
      col_l  <= req_addr[BYTE_W +: COL_W];
      wr_l   <= req_write;
      wd_l   <= req_wdata;
    end
    if (oe_n) dqo_q <= wd_l;
    if (rpipe[PIPE_L-1]) rd_data <= mem_dq_i;
  end

  logic [SW-1:0] s_act, s_pre, s_ref;
  logic          row_open, init_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_act    <= '1;
      s_pre    <= '1;
      s_ref    <= '1;
      row_open <= 1'b0;
      init_ok  <= 1'b0;
    end else begin
      s_act <= (cmd_q == CMD_ACT) ? SW'(1) : ((s_act != '1) ? s_act + 1'b1 : s_act);
      s_pre <= (cmd_q == CMD_PRE) ? SW'(1) : ((s_pre != '1) ? s_pre + 1'b1 : s_pre);
      s_ref <= (cmd_q == CMD_REF) ? SW'(1) : ((s_ref != '1) ? s_ref + 1'b1 : s_ref);
      if (cmd_q == CMD_ACT) row_open <= 1'b1;
      else if (cmd_q == CMD_PRE) row_open <= 1'b0;
      if (cmd_q == CMD_MRS) init_ok <= 1'b1;
    end
  end

  p_pwrup_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PWR) |-> (cmd_q == CMD_NOP && !req_ready && !oe_q));
  p_act_to_col_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> (s_act >= SW'(C_RCD)));
  p_ras_min_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_PRE && row_open) |-> (s_act >= SW'(C_RAS)));
  p_act_to_act_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_ACT) |-> (s_act >= SW'(C_RC)));
  p_pre_gap_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_ACT || cmd_q == CMD_REF) |-> (s_pre >= SW'(C_RP)));
  p_ref_gap_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_q != CMD_NOP) |-> (s_ref >= SW'(C_RFC)));
  p_ras_max_r9: assert property (@(posedge clk) disable iff (rst)
    row_open |-> (s_act < SW'(C_RASMAX)));
  p_ref_deadline_r10: assert property (@(posedge clk) disable iff (rst)
    init_ok |-> (s_ref <= SW'(C_REFI + SLACK)));
  p_oe_write_r11: assert property (@(posedge clk) disable iff (rst)
    oe_q |-> (cmd_q == CMD_WR));
  p_rdv_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
  p_take_act_r13: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (cmd_q == CMD_ACT));
  p_ready_closed_r13: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !row_open);

endmodule

// File: tb/sdram_seq_bench.sv
module sdram_seq_bench;

  localparam int TCK    = 8;
  localparam int CL     = 3;
  localparam int RT     = 2;
  localparam int LAT    = CL + RT;
  localparam int K_PWR  = 25000;
  localparam int K_RCD  = 3;
  localparam int K_RP   = 3;
  localparam int K_RAS  = 6;
  localparam int K_RC   = 9;
  localparam int K_RFC  = 9;
  localparam int K_MRD  = 2;
  localparam int K_WR   = 2;
  localparam int K_RMAX = 15000;
  localparam int K_REFI = 976;
  localparam int K_SLK  = 40;

  localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, RD = 4'b0101, WR = 4'b0100,
                         PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

  function automatic logic [26:0] mk(input int b, input int r, input int c);
    logic [1:0] bb; logic [12:0] rr; logic [9:0] cc;
    bb = b[1:0]; rr = r[12:0]; cc = c[9:0];
    return {bb, rr, cc, 2'b00};
  endfunction

  localparam logic [59:0] VEC [10] = '{
    {1'b1, mk(0, 5, 3),       32'h1111_0001},
    {1'b1, mk(1, 5, 3),       32'h2222_0002},
    {1'b1, mk(0, 9, 1023),    32'h3333_0003},
    {1'b1, mk(3, 8191, 0),    32'h4444_0004},
    {1'b0, mk(0, 5, 3),       32'h1111_0001},
    {1'b0, mk(0, 9, 1023),    32'h3333_0003},
    {1'b0, mk(3, 8191, 0),    32'h4444_0004},
    {1'b0, mk(1, 5, 3),       32'h2222_0002},
    {1'b1, mk(0, 5, 3),       32'h5555_0005},
    {1'b0, mk(0, 5, 3),       32'h5555_0005}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [26:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rd_valid;
  logic [31:0] rd_data;
  logic        cs_n, ras_n, cas_n, we_n;
  logic [1:0]  sd_ba;
  logic [12:0] sd_a;
  logic        sd_oe;
  logic [31:0] sd_do;
  logic [31:0] sd_di = '0;

  always #(TCK/2) clk = ~clk;

  sdram_seq u_sdram_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_cs_n(cs_n), .mem_ras_n(ras_n), .mem_cas_n(cas_n), .mem_we_n(we_n),
    .mem_ba(sd_ba), .mem_addr(sd_a), .mem_dq_oe(sd_oe), .mem_dq_o(sd_do), .mem_dq_i(sd_di)
  );

  logic [3:0] cmd;
  assign cmd = {cs_n, ras_n, cas_n, we_n};

  int checks = 0;
  int fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // pin-level memory model and timing monitor
  logic [31:0] mem [logic [24:0]];
  logic [12:0] open_row [4];
  logic [LAT-1:0] rdv = '0;
  logic [31:0] rdd [LAT];
  int ncyc = 0, first_cmd = -1, init_idx = 0;
  int last_act = -100000, last_pre = -100000, last_ref = -100000;
  int last_wr = -100000, last_mrs = -100000;
  bit init_done = 0, row_up = 0;
  int refs = 0, ref_with_valid = 0;

  always @(negedge clk) begin
    if (rst) begin
      ncyc = 0;
      rdv  = '0;
    end else begin
      logic [24:0] key;
      ncyc++;
      key = {sd_ba, open_row[sd_ba], sd_a[9:0]};
      for (int i = LAT - 1; i > 0; i--) rdd[i] = rdd[i-1];
      rdd[0] = (cmd == RD && mem.exists(key)) ? mem[key] : 32'h0;
      rdv = {rdv[LAT-2:0], cmd == RD};
      sd_di = rdv[LAT-1] ? rdd[LAT-1] : 32'h0;
      if (sd_oe && cmd != WR) chk(0, "R11", "drive outside WRITE", cmd, WR);
      if (cmd != NOP) begin
        if (first_cmd < 0) begin
          first_cmd = ncyc;
          chk(ncyc > K_PWR, "R1", "first command cycle", ncyc, K_PWR + 1);
        end
        if (last_mrs == ncyc - (ncyc - last_mrs) && last_mrs > last_ref && last_mrs > last_act
            && last_mrs > last_pre && last_mrs != ncyc)
          chk(ncyc - last_mrs >= K_MRD, "R2", "mode load gap", ncyc - last_mrs, K_MRD);
        chk(ncyc - last_ref >= K_RFC, "R8", "refresh to command", ncyc - last_ref, K_RFC);
        if (init_idx < 4) begin
          case (init_idx)
            0: chk(cmd == PRE && sd_a[10], "R2", "bring-up step 0", {cmd, sd_a}, {PRE, 13'h400});
            1, 2: chk(cmd == REF, "R2", "bring-up refresh", cmd, REF);
            default: chk(cmd == MRS && sd_a == 13'(CL << 4) && sd_ba == 2'd0, "R2",
                         "mode word", {cmd, sd_a}, {MRS, 13'(CL << 4)});
          endcase
          init_idx++;
        end
        case (cmd)
          ACT: begin
            chk(ncyc - last_pre >= K_RP, "R7", "precharge to active", ncyc - last_pre, K_RP);
            chk(ncyc - last_act >= K_RC, "R6", "active to active", ncyc - last_act, K_RC);
            open_row[sd_ba] = sd_a;
            last_act = ncyc;
            row_up = 1;
          end
          RD, WR: begin
            chk(ncyc - last_act >= K_RCD, "R5", "active to column", ncyc - last_act, K_RCD);
            if (cmd == WR) begin
              chk(sd_oe, "R11", "drive with WRITE", sd_oe, 1);
              mem[key] = sd_do;
              last_wr = ncyc;
            end
          end
          PRE: begin
            if (row_up) begin
              chk(ncyc - last_act >= K_RAS, "R6", "row open minimum", ncyc - last_act, K_RAS);
              chk(ncyc - last_act < K_RMAX, "R9", "row open maximum", ncyc - last_act, K_RMAX);
              if (last_wr > last_act)
                chk(ncyc - last_wr >= K_WR, "R6", "write recovery", ncyc - last_wr, K_WR);
            end
            row_up = 0;
            last_pre = ncyc;
          end
          REF: begin
            chk(ncyc - last_pre >= K_RP, "R7", "precharge to refresh", ncyc - last_pre, K_RP);
            if (init_done) begin
              chk(ncyc - last_ref <= K_REFI + K_SLK, "R10", "refresh spacing",
                  ncyc - last_ref, K_REFI + K_SLK);
              refs++;
              if (req_valid) ref_with_valid++;
            end
            last_ref = ncyc;
          end
          MRS: begin
            last_mrs = ncyc;
            init_done = 1;
          end
          default: chk(0, "R3", "unknown command", cmd, NOP);
        endcase
      end
    end
  end

  task automatic access(input bit wr, input logic [26:0] ad, input logic [31:0] d, input bit rdchk);
    int k;
    bit pre_seen, got;
    req_valid = 1'b1; req_write = wr; req_addr = ad; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(cmd == ACT && sd_ba == ad[26:25] && sd_a == ad[24:12], "R13", "active after take",
        {cmd, sd_ba, sd_a}, {ACT, ad[26:12]});
    k = 0;
    do begin @(negedge clk); k++; end while (cmd == NOP && k < 20);
    chk(cmd == (wr ? WR : RD) && sd_ba == ad[26:25] && sd_a == {3'b000, ad[11:2]}, "R4",
        "column command", {cmd, sd_ba, sd_a}, {(wr ? WR : RD), ad[26:25], 3'b000, ad[11:2]});
    if (wr) chk(sd_do == d, "R11", "write data", sd_do, d);
    k = 0; pre_seen = 0; got = 0;
    while (k < 30 && !(pre_seen && (wr || got))) begin
      @(negedge clk);
      k++;
      if (cmd != NOP && !pre_seen) begin
        chk(cmd == PRE && !sd_a[10] && sd_ba == ad[26:25], "R13", "single-bank close",
            {cmd, sd_a[10], sd_ba}, {PRE, 1'b0, ad[26:25]});
        pre_seen = 1;
      end
      if (!wr && rd_valid && !got) begin
        chk(k == LAT, "R12", "read latency", k, LAT);
        if (rdchk) chk(rd_data == d, "R12", "read data", rd_data, d);
        got = 1;
        @(negedge clk);
        k++;
        chk(!rd_valid, "R12", "valid pulse width", rd_valid, 0);
      end
    end
    chk(pre_seen && (wr || got), "R13", "access completed", {pre_seen, got}, 2'b11);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "R13", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int r0;
    repeat (4) @(negedge clk);
    chk(cmd == NOP && !sd_oe && !req_ready && !rd_valid, "R1", "reset state",
        {cmd, sd_oe, req_ready, rd_valid}, {NOP, 3'b000});
    rst = 1'b0;
    repeat (100) @(negedge clk);
    chk(!req_ready && cmd == NOP, "R1", "power-up quiet", {req_ready, cmd}, {1'b0, NOP});
    for (int i = 0; i < 10; i++)
      access(VEC[i][59], VEC[i][58:32], VEC[i][31:0], 1'b1);
    chk(init_idx == 4, "R2", "bring-up steps seen", init_idx, 4);
    r0 = refs;
    repeat (2500) @(negedge clk);
    chk(refs - r0 >= 2, "R10", "idle refreshes", refs - r0, 2);
    for (int i = 0; i < 200; i++)
      access(1'b1, mk(i % 4, 100 + i, i), 32'hA000_0000 + i, 1'b0);
    chk(ref_with_valid > 0, "R10", "refresh ahead of waiting request", ref_with_valid, 1);
    access(1'b0, mk(0, 100, 0), 32'hA000_0000, 1'b1);
    access(1'b0, mk(1, 157, 57), 32'hA000_0039, 1'b1);
    access(1'b0, mk(3, 299, 199), 32'hA000_00C7, 1'b1);
    repeat (20) @(negedge clk);
    finish_run();
  end

endmodule